// File: doc/BRIEF.md
# Per-Channel Line Alarm Interrupt Controller

This block gathers three kinds of per-channel alarm status for four line channels: signal loss, transmit driver fault and alarm-indication pattern. It samples each status input into a live status register. Every change of a status bit, rising or falling, is latched into a sticky pending register. Per-channel enable registers mask the pending bits, and the result drives one active-low level interrupt toward a host processor. The host reads the pending register to find out which channel changed, and that read also clears the register.

The host reaches the block through a simple synchronous register port with an address, a write strobe, a read strobe and registered read data. A write to the reset register starts a timed software reset. For its whole length the enable and pending registers are held at zero and register writes are refused. The length is derived from the master-clock frequency parameter: about one microsecond normally, and about two microseconds when the slow-bus input is set at the moment of the write.

Top module: `alm_irq_ctrl`

## Requirements
- R1: Status registers hold the input sampled at the previous clock edge, with bit n for channel n. They are at 04h (loss), 05h (driver fault) and 12h (alarm indication).
- R2: Any rising or falling edge on a channel's status input sets that channel's pending bit. Pending registers are at 08h (loss), 09h (driver fault) and 13h (alarm indication).
- R3: A read of a pending register returns its content and clears it. An edge that arrives in the same cycle as that read leaves its own bit set.
- R4: Enable registers are at 06h (loss), 07h (driver fault) and 14h (alarm indication). A write stores data bits 3..0, and bit n set to 1 enables channel n.
- R5: irq_n is low exactly while some pending bit has its enable bit set. It stays low without host action and goes high when the bit is cleared or its enable is removed.
- R6: reg_rdata is loaded on the clock edge where reg_rd is high. Bits 7..4 always read 0, and unmapped addresses read 0.
- R7: A write to 0Ah drives rst_busy high from the next cycle for ceil(CLK_KHZ/1000) cycles, or for ceil(2*CLK_KHZ/1000) cycles if long_mode is 1 at the write. A further write to 0Ah while busy does not extend the cycle.
- R8: From the reset write through the end of rst_busy, enable and pending registers are 0 and register writes have no effect. Status registers keep tracking their inputs, and edges seen in this window leave no pending bit.
- R9: After synchronous reset all registers read 0, irq_n is high and rst_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| long_mode | input | 1 | Selects the doubled software-reset length |
| los_in | input | 4 | Signal-loss status per channel |
| dfm_in | input | 4 | Driver-fault status per channel |
| ais_in | input | 4 | Alarm-indication status per channel |
| irq_n | output | 1 | Active-low level interrupt |
| rst_busy | output | 1 | Software reset cycle in progress |

## Verification
Two events can fall on the same edge: a host read that clears a pending register, and a new edge on a status input of another channel of the same source. The bench drives a change on channel 1 in the very cycle it reads the signal-loss pending register. It then expects the read to return only the older channel 0 bit, and a second read to return the channel 1 bit. It also issues an enable write and a second reset write during the reset cycle, and judges both by reading the registers back and counting the busy cycles.

// File: rtl/alm_irq_pkg.sv
package alm_irq_pkg;

    localparam int DW      = 8;
    localparam int AW      = 5;
    localparam int NUM_SRC = 3;

    localparam logic [AW-1:0] ADDR_SRST = 5'h0A;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } reg_req_t;

    // source 0: signal loss, 1: driver fault, 2: alarm indication
    function automatic logic [AW-1:0] sts_addr(input int src);
        case (src)
            0:       return 5'h04;
            1:       return 5'h05;
            default: return 5'h12;
        endcase
    endfunction

    function automatic logic [AW-1:0] en_addr(input int src);
        case (src)
            0:       return 5'h06;
            1:       return 5'h07;
            default: return 5'h14;
        endcase
    endfunction

    function automatic logic [AW-1:0] pend_addr(input int src);
        case (src)
            0:       return 5'h08;
            1:       return 5'h09;
            default: return 5'h13;
        endcase
    endfunction

    function automatic int reset_cycles(input int khz, input int usec);
        return (khz * usec + 999) / 1000;
    endfunction

endpackage

// File: rtl/alm_src_unit.sv
module alm_src_unit #(
    parameter int CH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CH-1:0] sts_in,
    input  logic          en_wr,
    input  logic [CH-1:0] en_wdata,
    input  logic          ack_rd,
    output logic [CH-1:0] sts_o,
    output logic [CH-1:0] pend_o,
    output logic [CH-1:0] en_o,
    output logic          req_o
);
    logic [CH-1:0] sts_q, pend_q, en_q;
    logic [CH-1:0] edge_hit;

    assign edge_hit = sts_in ^ sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            sts_q <= sts_in;
            if (clr) begin
                pend_q <= '0;
                en_q   <= '0;
            end else begin
                pend_q <= (ack_rd ? '0 : pend_q) | edge_hit;
                if (en_wr)
                    en_q <= en_wdata;
            end
        end
    end

    assign sts_o  = sts_q;
    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign req_o  = |(pend_q & en_q);

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!clr && sts_in == sts_q) |=> ((pend_q & ~$past(pend_q)) == '0)); // R2
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !clr && sts_in == sts_q) |=> (pend_q == '0)); // R3
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend_q == '0 && en_q == '0)); // R8

endmodule

// File: rtl/alm_srst_seq.sv
module alm_srst_seq
    import alm_irq_pkg::*;
#(
    parameter int CLK_KHZ = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_mode,
    output logic busy
);
    localparam int SHORT_CYC = reset_cycles(CLK_KHZ, 1);
    localparam int LONG_CYC  = reset_cycles(CLK_KHZ, 2);
    localparam int CW        = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
        else if (start)
            cnt_q <= long_mode ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
    import alm_irq_pkg::*;
#(
    parameter int CH      = 4,
    parameter int CLK_KHZ = 16384
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          long_mode,
    input  logic [CH-1:0] los_in,
    input  logic [CH-1:0] dfm_in,
    input  logic [CH-1:0] ais_in,
    output logic          irq_n,
    output logic          rst_busy
);
    reg_req_t      req;
    logic          srst_start, clr;
    logic [CH-1:0] sts_in [NUM_SRC];
    logic [CH-1:0] sts    [NUM_SRC];
    logic [CH-1:0] pend   [NUM_SRC];
    logic [CH-1:0] en     [NUM_SRC];
    logic [NUM_SRC-1:0] src_req;
    logic [DW-1:0] rd_mux;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

    assign sts_in[0] = los_in;
    assign sts_in[1] = dfm_in;
    assign sts_in[2] = ais_in;

    assign srst_start = req.wr && (req.addr == ADDR_SRST) && !rst_busy;
    assign clr        = srst_start || rst_busy;

    alm_srst_seq #(.CLK_KHZ(CLK_KHZ)) u_srst (
        .clk       (clk),
        .rst       (rst),
        .start     (srst_start),
        .long_mode (long_mode),
        .busy      (rst_busy)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        alm_src_unit #(.CH(CH)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr),
            .sts_in   (sts_in[s]),
            .en_wr    (req.wr && !rst_busy && (req.addr == en_addr(s))),
            .en_wdata (req.wdata[CH-1:0]),
            .ack_rd   (req.rd && (req.addr == pend_addr(s))),
            .sts_o    (sts[s]),
            .pend_o   (pend[s]),
            .en_o     (en[s]),
            .req_o    (src_req[s])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req.addr == sts_addr(s))  rd_mux = DW'(sts[s]);
            if (req.addr == en_addr(s))   rd_mux = DW'(en[s]);
            if (req.addr == pend_addr(s)) rd_mux = DW'(pend[s]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (req.rd)
            reg_rdata <= rd_mux;
    end

    assign irq_n = ~|src_req;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !reg_rd && !reg_wr) |=> !irq_n); // R5
    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (reg_rdata[DW-1:CH] == '0)); // R6

endmodule

// File: tb/alm_irq_ctrl_test.sv
module alm_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ        = 16384;
    localparam int EXP_SHORT  = (KHZ + 999) / 1000;
    localparam int EXP_LONG   = (2 * KHZ + 999) / 1000;

    localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] addr;
        logic [7:0] wd;
        logic [3:0] los;
        logic [3:0] dfm;
        logic [3:0] ais;
        logic [7:0] exp_rd;
        logic       exp_irq_n;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{OP_WR,   5'h06, 8'h05, 4'h0, 4'h0, 4'h0, 8'h00, 1'b1},
        '{OP_IDLE, 5'h00, 8'h00, 4'h1, 4'h0, 4'h0, 8'h00, 1'b0},
        '{OP_RD,   5'h04, 8'h00, 4'h1, 4'h0, 4'h0, 8'h01, 1'b0},
        '{OP_RD,   5'h08, 8'h00, 4'h1, 4'h0, 4'h0, 8'h01, 1'b1},
        '{OP_IDLE, 5'h00, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 1'b0},
        '{OP_RD,   5'h08, 8'h00, 4'h2, 4'h0, 4'h0, 8'h01, 1'b1},
        '{OP_RD,   5'h08, 8'h00, 4'h2, 4'h0, 4'h0, 8'h02, 1'b1},
        '{OP_WR,   5'h07, 8'hF3, 4'h2, 4'h0, 4'h0, 8'h00, 1'b1},
        '{OP_IDLE, 5'h00, 8'h00, 4'h2, 4'h2, 4'h0, 8'h00, 1'b0},
        '{OP_RD,   5'h07, 8'h00, 4'h2, 4'h2, 4'h0, 8'h03, 1'b0},
        '{OP_WR,   5'h07, 8'h00, 4'h2, 4'h2, 4'h0, 8'h00, 1'b1},
        '{OP_RD,   5'h09, 8'h00, 4'h2, 4'h2, 4'h0, 8'h02, 1'b1},
        '{OP_WR,   5'h14, 8'h08, 4'h2, 4'h2, 4'h0, 8'h00, 1'b1},
        '{OP_IDLE, 5'h00, 8'h00, 4'h2, 4'h2, 4'h8, 8'h00, 1'b0},
        '{OP_RD,   5'h12, 8'h00, 4'h2, 4'h2, 4'h8, 8'h08, 1'b0},
        '{OP_RD,   5'h13, 8'h00, 4'h2, 4'h2, 4'h8, 8'h08, 1'b1},
        '{OP_RD,   5'h1F, 8'h00, 4'h2, 4'h2, 4'h8, 8'h00, 1'b1},
        '{OP_RD,   5'h05, 8'h00, 4'h2, 4'h2, 4'h8, 8'h02, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, long_mode = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] los_in = '0, dfm_in = '0, ais_in = '0;
    logic       irq_n, rst_busy;

    int n_chk = 0, n_fail = 0, busy_cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_irq_ctrl #(.CH(4), .CLK_KHZ(KHZ)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .long_mode(long_mode), .los_in(los_in), .dfm_in(dfm_in), .ais_in(ais_in),
        .irq_n(irq_n), .rst_busy(rst_busy)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d);
        reg_wr    = (op == OP_WR);
        reg_rd    = (op == OP_RD);
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        if (rst_busy) busy_cyc++;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [4:0] regs [9] = '{5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h12, 5'h13, 5'h14};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk("R9 irq_n", int'(irq_n), 1);
        chk("R9 rst_busy", int'(rst_busy), 0);
        for (int i = 0; i < 9; i++) begin
            step(OP_RD, regs[i], 8'h00);
            chk("R9 register", int'(reg_rdata), 0);
        end

        // R1..R6: vector walk
        for (int i = 0; i < NV; i++) begin
            los_in = VEC[i].los;
            dfm_in = VEC[i].dfm;
            ais_in = VEC[i].ais;
            step(VEC[i].op, VEC[i].addr, VEC[i].wd);
            if (VEC[i].op == OP_RD)
                chk("R1/R2/R3/R4/R6 rdata", int'(reg_rdata), int'(VEC[i].exp_rd));
            chk("R5 irq_n", int'(irq_n), int'(VEC[i].exp_irq_n));
        end

        // R7/R8: short software reset with pending interrupt
        los_in = 4'h3;
        step(OP_IDLE, 5'h00, 8'h00);
        chk("R5 irq_n before reset", int'(irq_n), 0);
        busy_cyc = 0;
        step(OP_WR, 5'h0A, 8'h00);
        chk("R7 busy after write", int'(rst_busy), 1);
        chk("R8 irq_n cleared", int'(irq_n), 1);
        step(OP_WR, 5'h0A, 8'h00);
        step(OP_WR, 5'h06, 8'h0F);
        los_in = 4'h0;
        step(OP_IDLE, 5'h00, 8'h00);
        while (rst_busy) step(OP_IDLE, 5'h00, 8'h00);
        chk("R7 short length", busy_cyc, EXP_SHORT);
        step(OP_RD, 5'h06, 8'h00);
        chk("R8 enable write ignored", int'(reg_rdata), 0);
        step(OP_RD, 5'h08, 8'h00);
        chk("R8 pending empty", int'(reg_rdata), 0);
        step(OP_RD, 5'h04, 8'h00);
        chk("R8 status tracks", int'(reg_rdata), 0);

        // R7: long software reset
        long_mode = 1'b1;
        busy_cyc = 0;
        step(OP_WR, 5'h0A, 8'h00);
        long_mode = 1'b0;
        while (rst_busy) step(OP_IDLE, 5'h00, 8'h00);
        chk("R7 long length", busy_cyc, EXP_LONG);
        chk("R7 irq_n after", int'(irq_n), 1);

        done = 1'b1;
        finish_run();
    end

endmodule